// File: doc/BRIEF.md
# Lookup Table Indirect Access Port

This block holds a small on-chip table of 68-bit lookup entries and lets a host reach it through a narrow register window. The table itself is never mapped into the host's address space. Instead, the host works through three 32-bit staging words and an index control register.

To read, the host writes an index to the control register with the top bit clear. The selected entry is copied into the staging words, and the host can read them on the very next cycle. To write, the host fills the staging words and then writes the index with the top bit set. The staging contents are committed to that entry.

The staging words store the entry with the most significant word first:

- Word 2 holds entry bits 31:0.
- Word 1 holds bits 63:32.
- Word 0 holds the top four bits.

An identification register and a size status register let software find out the version and the table depth without prior knowledge.

Top module: `lut_access_port`

## Requirements
- R1: After reset every entry is free (all 68 bits zero), the three staging words read 0 and the control register reads 0.
- R2: Offset 0x00 reads the minor version in bits 7:0, the major version in bits 15:8 and zero above.
- R3: Offset 0x04 reads the size code in bits 4:0 (0 for the 64-entry build, otherwise the table holds code×1024 entries), zero above.
- R4: Staging words 0, 1 and 2 sit at offsets 0x34, 0x38 and 0x3C, and read back all 32 bits exactly as the host wrote them until the next fetch.
- R5: A control write (offset 0x20) with bit 31 clear fetches the entry selected by index bits 14:0 into the staging words: entry bit p lands in word 2−p/32 at bit p mod 32, and word 0 bits 31:4 read 0. The new contents are readable on the cycle right after the write.
- R6: A control write with bit 31 set commits the staging words to the indexed entry. Only bits 3:0 of word 0 are kept, and the staging words themselves are left unchanged.
- R7: The 2-bit entry type (0 free, 1 address, 2 VLAN, 3 VLAN plus address) occupies entry bits 61:60, and the 12-bit VLAN ID occupies bits 59:48. After a fetch these appear in word 1 at bits 29:28 and 27:16.
- R8: A commit to an index at or above the table size changes no entry, and a fetch of such an index loads all zeros.
- R9: The control register reads back the last index written in bits 14:0, with bit 31 and all other bits reading 0.
- R10: Offsets outside the mapped registers read 0, and writes to them change no register or entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from register state |

## Verification
The bench builds the block with its default parameters. These are size code 0 (a 64-entry table) and a 15-bit index field. With these values, indices from 64 up to the field's maximum 32767 exist in the index field but not in the table. This makes the out-of-range rules testable. It also makes aliasing testable: a commit to 69 must not reach entry 5. The small depth also lets random traffic revisit entries often enough that fetch-after-commit and word-0 truncation are exercised many times.

// File: rtl/lut_access_pkg.sv
package lut_access_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 3;
  localparam int ENTRY_W   = 68;
  localparam int ADDR_W    = 8;

  typedef logic [ENTRY_W-1:0]                entry_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0]  wordset_t;

  localparam logic [ADDR_W-1:0] OFS_IDVER = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h34;
  localparam int                DATA_STRIDE = 4;

  localparam int COMMIT_BIT    = 31;
  localparam int SIZE_FIELD_W  = 5;
  localparam int SMALL_ENTRIES = 64;
  localparam int SIZE_UNIT     = 1024;

  function automatic int entries_for(input int code);
    return (code == 0) ? SMALL_ENTRIES : code * SIZE_UNIT;
  endfunction

endpackage

// File: rtl/lut_access_pack.sv
module lut_access_pack
  import lut_access_pkg::*;
(
  input  wordset_t host_words,
  output entry_t   commit_entry,
  input  entry_t   fetch_entry,
  output wordset_t fetch_words
);

  // Staging words to entry: bit p comes from word (NUM_WORDS-1 - p/WORD_W)
  for (genvar p = 0; p < ENTRY_W; p++) begin : g_gather
    assign commit_entry[p] = host_words[NUM_WORDS-1-(p/WORD_W)][p%WORD_W];
  end

  // Entry to staging words: positions past the entry width read zero
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int POS = (NUM_WORDS - 1 - k) * WORD_W + b;
      if (POS < ENTRY_W) begin : g_live
        assign fetch_words[k][b] = fetch_entry[POS];
      end else begin : g_pad
        assign fetch_words[k][b] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lut_access_store.sv
module lut_access_store
  import lut_access_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  entry_t           commit_entry,
  output entry_t           fetch_entry
);

  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic   idx_ok;
  entry_t slot_view [ENTRIES];

  assign idx_ok = (int'(acc_idx) < ENTRIES);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    entry_t slot_q;
    entry_t slot_d;
    logic   slot_en;

    assign slot_en = commit_en && idx_ok && (acc_idx[AW-1:0] == AW'(e));

    always_comb begin
      slot_d = slot_q;
      if (slot_en) slot_d = commit_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign slot_view[e] = slot_q;
  end

  always_comb begin
    fetch_entry = '0;
    if (idx_ok) fetch_entry = slot_view[acc_idx[AW-1:0]];
  end

endmodule

// File: rtl/lut_access_regs.sv
module lut_access_regs
  import lut_access_pkg::*;
#(
  parameter int IDX_W     = 15,
  parameter int SIZE_CODE = 0,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output wordset_t          host_words,
  output logic [IDX_W-1:0]  acc_idx,
  output logic              commit_en,
  input  wordset_t          fetch_words
);

  logic                 ctl_hit;
  logic                 load_en;
  logic [NUM_WORDS-1:0] word_sel;
  logic [NUM_WORDS-1:0] word_hit;
  wordset_t             words_q, words_d;
  logic                 words_en;
  logic [IDX_W-1:0]     idx_q, idx_d;

  assign ctl_hit   = bus_we && (bus_addr == OFS_CTRL);
  assign commit_en = ctl_hit &&  bus_wdata[COMMIT_BIT];
  assign load_en   = ctl_hit && !bus_wdata[COMMIT_BIT];
  assign acc_idx   = bus_wdata[IDX_W-1:0];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_dec
    assign word_sel[k] = (bus_addr == ADDR_W'(int'(OFS_DATA) + k * DATA_STRIDE));
    assign word_hit[k] = bus_we && word_sel[k];
  end

  // Staging words: fetch has priority over a host write (they cannot coincide)
  always_comb begin
    words_d = words_q;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (load_en)          words_d[k] = fetch_words[k];
      else if (word_hit[k]) words_d[k] = bus_wdata;
    end
  end
  assign words_en = load_en || (|word_hit);

  always_comb begin
    idx_d = idx_q;
    if (ctl_hit) idx_d = bus_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        words_q <= '0;
    else if (words_en) words_q <= words_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (ctl_hit) idx_q <= idx_d;
  end

  assign host_words = words_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_IDVER)
      bus_rdata = {16'h0, 8'(VER_MAJOR), 8'(VER_MINOR)};
    else if (bus_addr == OFS_STAT)
      bus_rdata = {{(32-SIZE_FIELD_W){1'b0}}, SIZE_FIELD_W'(SIZE_CODE)};
    else if (bus_addr == OFS_CTRL)
      bus_rdata = 32'(idx_q);
    else begin
      for (int k = 0; k < NUM_WORDS; k++)
        if (word_sel[k]) bus_rdata = words_q[k];
    end
  end

endmodule

// File: rtl/lut_access_port.sv
module lut_access_port
  import lut_access_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter int IDX_W     = 15,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int ENTRIES = entries_for(SIZE_CODE);

  logic             rst_meta_q, rst_sync_q;
  wordset_t         data_words;
  wordset_t         fetch_words;
  entry_t           commit_entry;
  entry_t           fetch_entry;
  logic [IDX_W-1:0] acc_idx;
  logic             commit_en;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lut_access_regs #(
    .IDX_W     (IDX_W),
    .SIZE_CODE (SIZE_CODE),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .host_words  (data_words),
    .acc_idx     (acc_idx),
    .commit_en   (commit_en),
    .fetch_words (fetch_words)
  );

  lut_access_pack u_pack (
    .host_words   (data_words),
    .commit_entry (commit_entry),
    .fetch_entry  (fetch_entry),
    .fetch_words  (fetch_words)
  );

  lut_access_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .commit_en    (commit_en),
    .acc_idx      (acc_idx),
    .commit_entry (commit_entry),
    .fetch_entry  (fetch_entry)
  );

endmodule

// File: rtl/lut_access_chk.sv
module lut_access_chk
  import lut_access_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter int IDX_W     = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input wordset_t    words
);

  localparam int ENTRIES = entries_for(SIZE_CODE);

  logic ctl_wr, mapped;
  assign ctl_wr = bus_we && (bus_addr == OFS_CTRL);
  assign mapped = (bus_addr == OFS_IDVER) || (bus_addr == OFS_STAT) ||
                  (bus_addr == OFS_CTRL)  || (bus_addr == 8'h34) ||
                  (bus_addr == 8'h38)     || (bus_addr == 8'h3C);

  // R4: with no write at all, the staging words hold
  p_words_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(words));

  // R5: after a fetch, word 0 has nothing above the entry's top bits
  p_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[COMMIT_BIT]) |=> (words[0][31:4] == 28'h0));

  // R6: a commit leaves the staging words untouched
  p_commit_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[COMMIT_BIT]) |=> $stable(words));

  // R8: fetching beyond the table loads zeros
  p_oor_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[COMMIT_BIT] && (int'(bus_wdata[IDX_W-1:0]) >= ENTRIES))
    |=> (words == '0));

  // R9: the control register never shows the commit flag
  p_ctrl_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[COMMIT_BIT] == 1'b0));

  // R10: unmapped offsets read zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 32'h0));

endmodule

bind lut_access_port lut_access_chk #(
  .SIZE_CODE (SIZE_CODE),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .words     (data_words)
);

// File: tb/lut_access_port_test.sv
`timescale 1ns/1ps
module lut_access_port_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks;
  int failures;
  bit finished;

  logic [67:0] mdl_mem [64];
  logic [31:0] mdl_w   [3];
  logic [14:0] mdl_idx;

  lut_access_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [67:0] mdl_entry();
    logic [67:0] e;
    e = {mdl_w[0][3:0], mdl_w[1], mdl_w[2]};
    return e;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return 32'h0000_0104;
      8'h04:   return 32'h0;
      8'h20:   return {17'h0, mdl_idx};
      8'h34:   return mdl_w[0];
      8'h38:   return mdl_w[1];
      8'h3C:   return mdl_w[2];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_val(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic rd_check(input logic [7:0] a, input string tag);
    logic [31:0] d;
    bus_rd(a, d);
    check_val(tag, d, exp_read(a));
  endtask

  task automatic put_word(input int k, input logic [31:0] d);
    bus_wr(8'(8'h34 + 4 * k), d);
    mdl_w[k] = d;
  endtask

  task automatic ctrl(input logic [31:0] d);
    logic [14:0] i;
    logic [67:0] e;
    bus_wr(8'h20, d);
    i = d[14:0];
    mdl_idx = i;
    if (d[31]) begin
      if (i < 15'd64) mdl_mem[i[5:0]] = mdl_entry();
    end else begin
      e = (i < 15'd64) ? mdl_mem[i[5:0]] : 68'h0;
      mdl_w[2] = e[31:0];
      mdl_w[1] = e[63:32];
      mdl_w[0] = {28'h0, e[67:64]};
    end
  endtask

  task automatic check_words(input string tag);
    rd_check(8'h34, tag);
    rd_check(8'h38, tag);
    rd_check(8'h3C, tag);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [67:0] ent;
    void'($urandom(32'd1234));
    checks = 0; failures = 0; finished = 0;
    for (int i = 0; i < 64; i++) mdl_mem[i] = '0;
    for (int k = 0; k < 3; k++) mdl_w[k] = '0;
    mdl_idx = '0;
    bus_addr = 8'h0; bus_we = 1'b0; bus_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    check_words("R1");
    rd_check(8'h20, "R1");
    ctrl(32'd0);  check_words("R1");
    ctrl(32'd63); check_words("R1");

    // R2 / R3: identification and size
    rd_check(8'h00, "R2");
    rd_check(8'h04, "R3");

    // R4: staging words read back in full
    put_word(0, 32'hDEAD_BEEF);
    put_word(1, 32'h1234_5678);
    put_word(2, 32'hCAFE_F00D);
    check_words("R4");

    // R6: commit keeps staging words and trims word 0
    ctrl(32'h8000_0005);
    check_words("R6");
    put_word(0, 32'h0); put_word(1, 32'h0); put_word(2, 32'h0);
    ctrl(32'd5);
    check_val("R6", mdl_w[0], 32'h0000_000F);
    check_words("R5");

    // R5: fetched data visible on the cycle right after the control write
    ctrl(32'd5);
    bus_rd(8'h38, d);
    check_val("R5", d, 32'h1234_5678);

    // R7: type and VLAN ID fields in word 1
    ent = '0;
    ent[61:60] = 2'd3;
    ent[59:48] = 12'hABC;
    ent[67:64] = 4'h9;
    ent[31:0]  = 32'h0BAD_CAFE;
    put_word(2, ent[31:0]); put_word(1, ent[63:32]); put_word(0, {28'h0, ent[67:64]});
    ctrl(32'h8000_000A);
    put_word(1, 32'hFFFF_FFFF);
    ctrl(32'd10);
    bus_rd(8'h38, d);
    check_val("R7", {30'h0, d[29:28]}, 32'd3);
    check_val("R7", {20'h0, d[27:16]}, 32'hABC);

    // R8: out-of-range commit and fetch
    put_word(0, 32'h5); put_word(1, 32'h5555_5555); put_word(2, 32'hAAAA_AAAA);
    ctrl(32'h8000_0045);
    ctrl(32'd5);
    check_words("R8");
    ctrl(32'd69);
    check_words("R8");
    ctrl(32'h0000_7FFF);
    check_words("R8");

    // R9: control readback masks flag and high bits
    ctrl(32'h8000_0007);
    rd_check(8'h20, "R9");
    ctrl(32'h7FFF_0003);
    bus_rd(8'h20, d);
    check_val("R9", d, 32'h3);

    // R10: unmapped offsets
    bus_wr(8'h44, 32'hFFFF_FFFF);
    rd_check(8'h44, "R10");
    rd_check(8'h24, "R10");
    check_words("R10");
    rd_check(8'h20, "R10");

    // Random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: put_word(int'($urandom_range(0, 2)), $urandom());
        1: ctrl({1'b1, 16'h0, 15'($urandom_range(0, 79))});
        2: begin
             ctrl({1'b0, 16'h0, 15'($urandom_range(0, 79))});
             check_words("R5");
           end
        default: rd_check(8'(8'h34 + 4 * $urandom_range(0, 2)), "R4");
      endcase
    end
    for (int i = 0; i < 64; i += 9) begin
      ctrl(32'(i));
      check_words("R6");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule